// File: doc/BRIEF.md
# PHY Power-Up Initialization Sequencer

This block wakes an SD/eMMC pad PHY after a system reset without any software involvement. Once reset is released it walks a fixed list of register steps over a simple indirect-access master port. Most steps read a PHY register, OR in a set of enable bits and write the result back. The sequence first arms the pad power and resistor-trim controls. It then polls a status register until pad calibration reports completion. Only after that does it enable the receivers, pull-ups and drivers of the command, data, strobe and clock lines, widen the clock buffer selection, and finally force the PHY into its legacy (low-speed) timing mode.

Every access has a bounded wait for its acknowledge. The calibration poll has a bounded overall window. Either timeout stops the sequence with an error flag. A successful walk of all steps raises a done flag. Both flags hold until the next reset, so a boot controller can sample them at leisure.

Top module: `phy_init_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `phy_req`, `init_done` and `init_err` are all 0.
- R2: Once `phy_req` is raised, `phy_addr`, `phy_we` and `phy_wdata` stay unchanged until `phy_ack` is seen. In the cycle after an acknowledged cycle, `phy_req` is 0.
- R3: The first steps are two read-then-write pairs: address 0x01 is written with its read value OR 0x42 (bits 6 and 1), then address 0x02 with its read value OR 0x02 (bit 1).
- R4: Address 0x03 is then read repeatedly until a read returns bit 4 (0x10) set. No other address is accessed between the write of 0x02 and that read.
- R5: After calibration, the read-modify-write steps run in this order, with these OR masks: 0x06 |= 0x03, 0x08 |= 0x02, 0x20 |= 0x01, 0x07 |= 0xFF, 0x09 |= 0xFF, 0x21 |= 0xFF, 0x22 |= 0x01, 0x23 |= 0x01, 0x0F |= 0x07.
- R6: The last access is a write of 0x04 to address 0x11, issued without a preceding read of 0x11.
- R7: If an access is not acknowledged within `ACK_CYCLES` cycles of `phy_req` rising, `init_err` is set and no further request is issued.
- R8: If bit 4 of address 0x03 is not seen set within `POLL_CYCLES` cycles of the poll starting, `init_err` is set. No line register (0x06 onward) is then written.
- R9: `init_done` rises only after the write to 0x11 is acknowledged. `init_done` and `init_err` are never both 1. Each stays 1 until reset.
- R10: Each read-modify-write changes only the masked bits; all other bits of the register keep the value read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_req | output | 1 | Access request, held until acknowledged or timed out |
| phy_we | output | 1 | 1 = write access, 0 = read access |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 8 | Write data |
| phy_ack | input | 1 | One-cycle acknowledge from the PHY side |
| phy_rdata | input | 8 | Read data, valid in the acknowledge cycle |
| init_done | output | 1 | Sequence completed successfully (sticky) |
| init_err | output | 1 | Sequence aborted on a timeout (sticky) |

## Verification
The handshake assertions assume the PHY side raises `phy_ack` only while `phy_req` is high, for a single cycle, with `phy_rdata` valid in that same cycle. The bench PHY model keeps within this by answering only a pending, not-yet-acknowledged request, and by registering the acknowledge and the data together. The sticky and exclusivity checks assume reset is held for at least one clock edge at start-up. Every scenario task does so before releasing reset. The model varies the acknowledge latency and calibration delay, and it can refuse one address to provoke an access timeout.

// File: rtl/phy_init_pkg.sv
// Package: shared widths, step encoding and the fixed power-up step list.
// Assumes an 8-bit register address and data path on the PHY side.
package phy_init_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_STEPS = 13;

    typedef enum logic [1:0] {
        K_RMW   = 2'd0,   // read, OR in bits, write back
        K_POLL  = 2'd1,   // read until any masked bit is set
        K_WRITE = 2'd2    // plain write of the bits field
    } step_kind_t;

    typedef struct packed {
        step_kind_t          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   bits;
    } step_t;

    // Step list; the order is the required bring-up order.
    function automatic step_t step_at(input int idx);
        step_t s;
        case (idx)
            0:       s = '{K_RMW,   8'h01, 8'h42};  // pad power + retention
            1:       s = '{K_RMW,   8'h02, 8'h02};  // resistor trim enable
            2:       s = '{K_POLL,  8'h03, 8'h10};  // calibration complete
            3:       s = '{K_RMW,   8'h06, 8'h03};  // cmd + strobe receivers
            4:       s = '{K_RMW,   8'h08, 8'h02};  // cmd pull-up
            5:       s = '{K_RMW,   8'h20, 8'h01};  // cmd driver
            6:       s = '{K_RMW,   8'h07, 8'hFF};  // data receivers
            7:       s = '{K_RMW,   8'h09, 8'hFF};  // data pull-ups
            8:       s = '{K_RMW,   8'h21, 8'hFF};  // data drivers
            9:       s = '{K_RMW,   8'h22, 8'h01};  // strobe driver
            10:      s = '{K_RMW,   8'h23, 8'h01};  // clock driver
            11:      s = '{K_RMW,   8'h0F, 8'h07};  // widest clock buffer
            default: s = '{K_WRITE, 8'h11, 8'h04};  // legacy timing mode
        endcase
        return s;
    endfunction

endpackage

// File: rtl/phy_init_steps.sv
// Module: step lookup. Maps a step index to its kind, address and bit field,
// and flags the final step. Purely combinational; assumes idx < NUM_STEPS.
module phy_init_steps
    import phy_init_pkg::*;
#(
    parameter int IDX_W = $clog2(NUM_STEPS)
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step,
    output logic             last
);

    // Decode the current step from the package list.
    always_comb begin
        step = step_at(int'(idx));
        last = (int'(idx) == NUM_STEPS - 1);
    end

endmodule

// File: rtl/phy_init_timer.sv
// Module: saturating window timer. Restarts on clr and flags expiry after
// LIMIT cycles. Assumes LIMIT >= 1.
module phy_init_timer #(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count up from clear, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Window is exhausted once the limit is reached.
    always_comb expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/phy_init_port.sv
// Module: indirect-access master. Latches one access on start, holds the
// request until acknowledge or until ACK_CYCLES elapse, then pulses fin or
// fail for one cycle. Assumes start is only raised while idle.
module phy_init_port
    import phy_init_pkg::*;
#(
    parameter int ACK_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              fin,
    output logic              fail,
    output logic [DATA_W-1:0] rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata
);

    localparam int CW = $clog2(ACK_CYCLES + 1);

    logic          busy;
    logic [CW-1:0] cnt;

    // Run one access: latch, wait for acknowledge, or give up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            fin       <= 1'b0;
            fail      <= 1'b0;
            rdata     <= '0;
            phy_we    <= 1'b0;
            phy_addr  <= '0;
            phy_wdata <= '0;
        end else begin
            fin  <= 1'b0;
            fail <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    cnt       <= '0;
                    phy_we    <= we_in;
                    phy_addr  <= addr_in;
                    phy_wdata <= wdata_in;
                end
            end else if (phy_ack) begin
                busy  <= 1'b0;
                fin   <= 1'b1;
                rdata <= phy_rdata;
            end else if (cnt == CW'(ACK_CYCLES - 1)) begin
                busy <= 1'b0;
                fail <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The request is the busy flag itself.
    always_comb phy_req = busy;

    // R2: address, direction and data hold while a request waits.
    p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)))
        else $error("request fields changed while pending");

    // R2: an acknowledged request is dropped in the next cycle.
    p_req_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req)
        else $error("request still high after acknowledge");

endmodule

// File: rtl/phy_init_seq.sv
// Module: power-up sequencer top. Steps through the fixed list: RMW steps
// read then write back with bits ORed in, the poll step re-reads until a
// masked bit is set within POLL_CYCLES, the final step is a plain write.
// Any timeout ends in a sticky error; full success ends in a sticky done.
// Assumes the PHY acknowledges for one cycle, only while requested.
module phy_init_seq
    import phy_init_pkg::*;
#(
    parameter int ACK_CYCLES  = 64,
    parameter int POLL_CYCLES = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              init_done,
    output logic              init_err
);

    localparam int IDX_W = $clog2(NUM_STEPS);

    typedef enum logic [2:0] {
        S_FETCH, S_RD_GO, S_RD_WAIT, S_WR_GO, S_WR_WAIT, S_ADV, S_DONE, S_ERR
    } state_t;

    state_t            state;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wbuf;
    step_t             step;
    logic              last;
    logic              start;
    logic              acc_we;
    logic              fin;
    logic              fail;
    logic [DATA_W-1:0] rdata;
    logic              poll_expired;
    logic              poll_hit;

    phy_init_steps #(.IDX_W(IDX_W)) u_steps (
        .idx  (idx),
        .step (step),
        .last (last)
    );

    phy_init_port #(.ACK_CYCLES(ACK_CYCLES)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .we_in     (acc_we),
        .addr_in   (step.addr),
        .wdata_in  (wbuf),
        .fin       (fin),
        .fail      (fail),
        .rdata     (rdata),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata)
    );

    phy_init_timer #(.LIMIT(POLL_CYCLES)) u_poll_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == S_FETCH),
        .expired (poll_expired)
    );

    // Access launch controls and the poll completion test.
    always_comb begin
        start    = (state == S_RD_GO) || (state == S_WR_GO);
        acc_we   = (state == S_WR_GO);
        poll_hit = |(rdata & step.bits);
    end

    // Step sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
            idx   <= '0;
            wbuf  <= '0;
        end else begin
            unique case (state)
                S_FETCH: begin
                    if (step.kind == K_WRITE) begin
                        wbuf  <= step.bits;
                        state <= S_WR_GO;
                    end else begin
                        state <= S_RD_GO;
                    end
                end
                S_RD_GO:   state <= S_RD_WAIT;
                S_RD_WAIT: begin
                    if (fail) begin
                        state <= S_ERR;
                    end else if (fin) begin
                        if (step.kind == K_POLL) begin
                            if (poll_hit)          state <= S_ADV;
                            else if (poll_expired) state <= S_ERR;
                            else                   state <= S_RD_GO;
                        end else begin
                            wbuf  <= rdata | step.bits;
                            state <= S_WR_GO;
                        end
                    end
                end
                S_WR_GO:   state <= S_WR_WAIT;
                S_WR_WAIT: begin
                    if (fail)     state <= S_ERR;
                    else if (fin) state <= S_ADV;
                end
                S_ADV: begin
                    if (last) begin
                        state <= S_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_DONE:  state <= S_DONE;
                default: state <= S_ERR;
            endcase
        end
    end

    // Outcome flags, held by the terminal states.
    always_comb begin
        init_done = (state == S_DONE);
        init_err  = (state == S_ERR);
    end

    // R1: reset clears request and outcome flags.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!phy_req && !init_done && !init_err))
        else $error("outputs active after reset");

    // R9: success and failure are exclusive.
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && init_err))
        else $error("done and error both set");

    // R9: done is sticky.
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done)
        else $error("done dropped");

    // R9: error is sticky.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err)
        else $error("error dropped");

    // R7: no request once the sequence has ended.
    p_quiet_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done || init_err) |-> !phy_req)
        else $error("request after sequence end");

endmodule

// File: tb/phy_init_seq_bench.sv
// Bench: directed scenarios against a behavioural PHY register model.
module phy_init_seq_bench;

    localparam int ACK_T  = 16;
    localparam int POLL_T = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phy_req, phy_we, phy_ack = 1'b0;
    logic [7:0] phy_addr, phy_wdata, phy_rdata = 8'h00;
    logic       init_done, init_err;

    always #4 clk = ~clk;  // 125 MHz

    phy_init_seq #(.ACK_CYCLES(ACK_T), .POLL_CYCLES(POLL_T)) u_phy_init_seq (
        .clk(clk), .rst_n(rst_n),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .init_done(init_done), .init_err(init_err)
    );

    // ---------------- PHY model ----------------
    logic [7:0] mem [256];
    logic [7:0] init_img [256];
    int  latency, cal_delay, hang_addr;
    bit  cal_never;
    int  lat_cnt, cal_cnt;
    bit  cal_armed;
    int  cycle, w02_cycle;
    int  viol;
    bit  log_we [1024];
    logic [7:0] log_addr [1024];
    logic [7:0] log_data [1024];
    int  log_n;
    logic       prev_req, prev_ack, prev_we;
    logic [7:0] prev_addr, prev_wdata;

    always @(posedge clk) begin
        cycle = cycle + 1;
        if (!rst_n) begin
            phy_ack  <= 1'b0;
            lat_cnt   = 0;
            cal_armed = 0;
            cal_cnt   = 0;
            prev_req  = 1'b0;
            prev_ack  = 1'b0;
        end else begin
            if (prev_req && !prev_ack &&
                (phy_addr != prev_addr || phy_we != prev_we || phy_wdata != prev_wdata))
                viol = viol + 1;
            if (prev_req && prev_ack && phy_req) viol = viol + 1;
            phy_ack <= 1'b0;
            if (cal_armed && !cal_never) begin
                if (cal_cnt >= cal_delay) mem[3] = mem[3] | 8'h10;
                else cal_cnt = cal_cnt + 1;
            end
            if (phy_req && !phy_ack && hang_addr != int'(phy_addr)) begin
                if (lat_cnt >= latency) begin
                    lat_cnt = 0;
                    phy_ack <= 1'b1;
                    if (log_n < 1024) begin
                        log_we[log_n]   = phy_we;
                        log_addr[log_n] = phy_addr;
                        log_data[log_n] = phy_we ? phy_wdata : mem[phy_addr];
                        log_n = log_n + 1;
                    end
                    if (phy_we) begin
                        mem[phy_addr] = phy_wdata;
                        if (phy_addr == 8'h02 && phy_wdata[1] && !cal_armed) begin
                            cal_armed = 1;
                            cal_cnt   = 0;
                            w02_cycle = cycle;
                        end
                    end else begin
                        phy_rdata <= mem[phy_addr];
                    end
                end else begin
                    lat_cnt = lat_cnt + 1;
                end
            end
            prev_req   = phy_req;
            prev_ack   = phy_ack;
            prev_we    = phy_we;
            prev_addr  = phy_addr;
            prev_wdata = phy_wdata;
        end
    end

    // ---------------- bookkeeping ----------------
    int  n_checks, n_fail;
    bit  finished;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // Expected step list, bench's own copy.
    function automatic logic [7:0] exp_addr(input int i);
        logic [7:0] a [13] = '{8'h01, 8'h02, 8'h03, 8'h06, 8'h08, 8'h20, 8'h07,
                               8'h09, 8'h21, 8'h22, 8'h23, 8'h0F, 8'h11};
        return a[i];
    endfunction
    function automatic logic [7:0] exp_mask(input int i);
        logic [7:0] m [13] = '{8'h42, 8'h02, 8'h10, 8'h03, 8'h02, 8'h01, 8'hFF,
                               8'hFF, 8'hFF, 8'h01, 8'h01, 8'h07, 8'h04};
        return m[i];
    endfunction

    task automatic setup(input int seed, input int lat, input int cdel,
                         input bit never, input int hang);
        rst_n = 1'b0;
        latency = lat; cal_delay = cdel; cal_never = never; hang_addr = hang;
        log_n = 0; viol = 0;
        for (int a = 0; a < 256; a++) begin
            mem[a] = 8'((a * 37 + seed) & 8'hFF);
            if (a == 3) mem[a] = mem[a] & 8'hEF;
            init_img[a] = mem[a];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_end(input int limit, output int took);
        took = 0;
        while (!init_done && !init_err && took < limit) begin
            @(negedge clk);
            took++;
        end
    endtask

    // Builds the expected access list (0x03 reads collapsed) and compares.
    task automatic check_log(input string rq);
        int e;
        int k;
        bit ok;
        e = 0; ok = 1;
        k = 0;
        while (k < log_n) begin
            int step;
            bit is_rd;
            if (k > 0 && !log_we[k] && log_addr[k] == 8'h03 &&
                !log_we[k-1] && log_addr[k-1] == 8'h03) begin
                k++;
                continue;
            end
            // Map expected entry e to step and phase.
            if (e < 4)        begin step = e / 2;            is_rd = (e % 2) == 0; end
            else if (e == 4)  begin step = 2;                is_rd = 1;            end
            else if (e < 23)  begin step = 3 + (e - 5) / 2;  is_rd = ((e - 5) % 2) == 0; end
            else              begin step = 12;               is_rd = 0;            end
            if (e >= 24 || log_addr[k] != exp_addr(step) || log_we[k] == is_rd) ok = 0;
            else if (!is_rd && step != 12 &&
                     log_data[k] != (init_img[exp_addr(step)] | exp_mask(step))) ok = 0;
            else if (step == 12 && log_data[k] != 8'h04) ok = 0;
            e++; k++;
        end
        chk(ok && e == 24, rq, "access order/values (entries)", e, 24);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        setup(5, 0, 0, 0, -1);
        chk(!phy_req && !init_done && !init_err, "R1", "outputs in reset",
            {phy_req, init_done, init_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!phy_req && !init_done && !init_err, "R1", "outputs after release",
            {phy_req, init_done, init_err}, 0);
    endtask

    task automatic t_normal(input int seed, input int lat, input int cdel);
        int took;
        int n03;
        setup(seed, lat, cdel, 0, -1);
        rst_n = 1'b1;
        wait_end(20000, took);
        chk(init_done && !init_err, "R9", "done without error",
            {init_done, init_err}, 2);
        check_log("R3 R4 R5 R6");
        chk(log_n > 0 && log_we[log_n-1] && log_addr[log_n-1] == 8'h11, "R6",
            "last access is write to 0x11", int'(log_addr[log_n-1]), 8'h11);
        chk(log_n > 1 && log_addr[log_n-2] != 8'h11, "R6", "no read of 0x11",
            int'(log_addr[log_n-2]), 8'h0F);
        n03 = 0;
        for (int k = 0; k < log_n; k++) if (log_addr[k] == 8'h03) n03++;
        chk(cdel < 20 || n03 > 1, "R4", "calibration polled repeatedly", n03, 2);
        for (int i = 0; i < 12; i++) begin
            if (i == 2) continue;
            chk(mem[exp_addr(i)] == (init_img[exp_addr(i)] | exp_mask(i)), "R10",
                "masked OR preserves other bits", int'(mem[exp_addr(i)]),
                int'(init_img[exp_addr(i)] | exp_mask(i)));
        end
        chk(mem[8'h11] == 8'h04, "R6", "legacy mode value", int'(mem[8'h11]), 4);
        chk(viol == 0, "R2", "handshake hold/gap violations", viol, 0);
        repeat (50) @(negedge clk);
        chk(init_done && !init_err && !phy_req, "R9", "done sticky, bus quiet",
            {init_done, init_err, phy_req}, 4);
    endtask

    task automatic t_cal_timeout();
        int took;
        bit line_touched;
        setup(77, 1, 0, 1, -1);
        rst_n = 1'b1;
        wait_end(20000, took);
        chk(init_err && !init_done, "R8", "error on calibration timeout",
            {init_done, init_err}, 1);
        chk((cycle - w02_cycle) >= POLL_T, "R8", "poll window honoured",
            cycle - w02_cycle, POLL_T);
        line_touched = 0;
        for (int k = 0; k < log_n; k++)
            if (log_addr[k] != 8'h01 && log_addr[k] != 8'h02 && log_addr[k] != 8'h03)
                line_touched = 1;
        chk(!line_touched, "R8", "no line register accessed", line_touched, 0);
        chk(mem[8'h06] == init_img[8'h06], "R8", "reg 0x06 untouched",
            int'(mem[8'h06]), int'(init_img[8'h06]));
        repeat (40) @(negedge clk);
        chk(init_err && !init_done && !phy_req, "R9", "error sticky, bus quiet",
            {init_done, init_err, phy_req}, 2);
    endtask

    task automatic t_ack_timeout();
        int took;
        int n_before;
        setup(200, 2, 3, 0, 8'h21);
        rst_n = 1'b1;
        wait_end(20000, took);
        chk(init_err && !init_done, "R7", "error on missing acknowledge",
            {init_done, init_err}, 1);
        chk(log_n > 0 && log_we[log_n-1] && log_addr[log_n-1] == 8'h09, "R7",
            "last completed access is write 0x09", int'(log_addr[log_n-1]), 8'h09);
        n_before = log_n;
        repeat (60) @(negedge clk);
        chk(log_n == n_before && !phy_req, "R7", "no request after error",
            log_n, n_before);
        chk(mem[8'h22] == init_img[8'h22] && mem[8'h21] == init_img[8'h21], "R7",
            "later registers untouched", int'(mem[8'h22]), int'(init_img[8'h22]));
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cycle = 0; n_checks = 0; n_fail = 0; finished = 0;
        latency = 0; cal_delay = 0; cal_never = 0; hang_addr = -1;
        t_reset();
        t_normal(11, 0, 0);
        t_normal(150, 2, 150);
        t_normal(0, 1, 40);
        t_cal_timeout();
        t_ack_timeout();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule